// File: doc/BRIEF.md
# Programmable Sum-of-Products Array

This block is the logic core of a small fuse-programmed logic device. It forms ten output sums. Each sum is the OR of its own group of product terms. Each product term is the AND of any chosen subset of 44 array columns. Those columns are the true and inverted copies of 12 pin inputs and of 10 feedback lines. The feedback lines come back from output cells that sit outside this block, so the array itself holds no combinational loop.

The terms are shared out unevenly. The two outermost outputs get 8 terms each. Each pair further in gets 2 more, up to 16 terms for the two central outputs. Output registers, polarity and drivers belong to the surrounding cell logic.

The configuration is one flat fuse vector. It is shifted in one bit per clock into a shadow register, first bit first. A separate load strobe copies the shadow into the active fuse set, which then stays fixed. The upper 64 bits of the vector are a user signature. The signature can be read back, but it takes no part in the logic. The sums follow the pins, the feedback and the active fuses with no clock in the path.

Top module: `pla_sop_array`

## Requirements
- R1: While reset is low, the shadow and active fuse sets clear to zero, so every sum and every signature bit reads 0.
- R2: Each clock with the shift enable high moves the shadow one place toward its top and enters the serial bit at index 0. After 5344 shifts, the first bit sent sits at fuse 5343.
- R3: The active fuses change only on a clock with the load strobe high. On that clock they take the shadow contents from before that edge. Shifting with no load leaves the sums and the signature unchanged.
- R4: Array signal s is pin s for s below 12, and feedback line s-12 otherwise. Column 2s carries signal s and column 2s+1 carries its inverse. Fuse index term*44+column set to 1 connects that column into that term.
- R5: A column whose fuse is 0 has no effect on its term.
- R6: A term that connects both the true and the inverted column of the same signal is always 0.
- R7: A term with no connected column is 0, so an output whose terms are all empty reads 0.
- R8: Output k is the OR of its terms. The term counts for outputs 0 through 9 are 8,10,12,14,16,16,14,12,10,8. Terms are numbered consecutively, starting with output 0.
- R9: The last term of an output drives that output only, never the next one.
- R10: Fuses 5343 down to 5280 appear on the signature port, with fuse 5280 at bit 0, and never change any sum.
- R11: The sums respond to pin and feedback changes without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low reset of shadow and active fuses |
| pin_i | input | 12 | Dedicated pin inputs to the array |
| fb_i | input | 10 | Feedback from the ten output cells |
| cfg_bit_i | input | 1 | Serial fuse data |
| cfg_shift_i | input | 1 | Shift enable for the shadow register |
| cfg_load_i | input | 1 | Copy shadow into active fuses |
| sum_o | output | 10 | Sum-of-products results |
| sig_o | output | 64 | User signature readback |

## Verification
The bench aims at term budget edges. It places terms at the last slot of outputs 3, 4 and 9 and at the first slot of output 5. A wrong term start or term count would make the wrong output respond. A term with both polarities of one pin and an empty term must hold low. A design that ignored the contradiction, or treated an empty AND as 1, would raise its output.

A second image is shifted in without a load, and the outputs must not move. Early transfer would show the new logic at once. The signature pattern is asymmetric, so a serial order reversed end to end shows up at once in the readback.

// File: rtl/pla_pkg.sv
package pla_pkg;

   // Number of product terms owned by output k: mirrored pairs growing inward.
   function automatic int term_count(input int k, input int n_out,
                                     input int base, input int step);
      int d;
      d = (k < n_out - 1 - k) ? k : (n_out - 1 - k);
      return base + step * d;
   endfunction

   // Global index of the first term of output k.
   function automatic int term_start(input int k, input int n_out,
                                     input int base, input int step);
      int acc;
      acc = 0;
      for (int i = 0; i < k; i++) acc += term_count(i, n_out, base, step);
      return acc;
   endfunction

endpackage

// File: rtl/pla_fuse_store.sv
module pla_fuse_store #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bit_i,
   input  logic         shift_i,
   input  logic         load_i,
   output logic [W-1:0] act_o
);

   logic [W-1:0] shadow_q;
   logic [W-1:0] act_q;

   generate
      if (W < 2) begin : g_bad_w
         $error("pla_fuse_store: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
      end else if (shift_i) begin
         shadow_q <= {shadow_q[W-2:0], bit_i};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= '0;
      end else if (load_i) begin
         act_q <= shadow_q;
      end
   end

   assign act_o = act_q;

   // R2: the serial bit enters at the bottom and the old bottom moves up.
   a_r2_shift_entry: assert property (@(posedge clk) disable iff (!rst_n)
      shift_i |=> (shadow_q[0] == $past(bit_i)) && (shadow_q[1] == $past(shadow_q[0])));

   // R3: a load takes the shadow from before the edge.
   a_r3_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> act_q == $past(shadow_q));

   // R3: without a load the active fuses hold.
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(act_q));

endmodule

// File: rtl/pla_pterm.sv
module pla_pterm #(
   parameter int COLS = 44
) (
   input  logic [COLS-1:0] fuse_i,
   input  logic [COLS-1:0] col_i,
   output logic            term_o
);

   logic any_sel;
   logic all_true;

   generate
      if (COLS < 2 || (COLS % 2) != 0) begin : g_bad_cols
         $error("pla_pterm: COLS must be even and at least 2");
      end
   endgenerate

   // A disconnected column is forced to 1; an empty term is forced to 0.
   always_comb begin
      any_sel  = |fuse_i;
      all_true = &(col_i | ~fuse_i);
      term_o   = any_sel & all_true;
   end

endmodule

// File: rtl/pla_or_cell.sv
module pla_or_cell #(
   parameter int N_TERMS = 8,
   parameter int COLS    = 44,
   localparam int FW     = N_TERMS * COLS
) (
   input  logic [FW-1:0]   fuse_i,
   input  logic [COLS-1:0] col_i,
   output logic            sum_o
);

   logic [N_TERMS-1:0] terms;

   generate
      if (N_TERMS < 1) begin : g_bad_terms
         $error("pla_or_cell: N_TERMS must be at least 1");
      end
      for (genvar t = 0; t < N_TERMS; t++) begin : g_term
         pla_pterm #(.COLS(COLS)) u_term (
            .fuse_i (fuse_i[t*COLS +: COLS]),
            .col_i  (col_i),
            .term_o (terms[t])
         );
      end
   endgenerate

   assign sum_o = |terms;

endmodule

// File: rtl/pla_sop_array.sv
module pla_sop_array #(
   parameter int N_PIN      = 12,
   parameter int N_OUT      = 10,
   parameter int BASE_TERMS = 8,
   parameter int TERM_STEP  = 2,
   parameter int SIG_W      = 64,
   localparam int N_SIG     = N_PIN + N_OUT,
   localparam int COLS      = 2 * N_SIG,
   localparam int TOT_TERMS = pla_pkg::term_start(N_OUT, N_OUT, BASE_TERMS, TERM_STEP),
   localparam int AND_W     = TOT_TERMS * COLS,
   localparam int FUSE_W    = AND_W + SIG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_PIN-1:0] pin_i,
   input  logic [N_OUT-1:0] fb_i,
   input  logic             cfg_bit_i,
   input  logic             cfg_shift_i,
   input  logic             cfg_load_i,
   output logic [N_OUT-1:0] sum_o,
   output logic [SIG_W-1:0] sig_o
);

   logic [FUSE_W-1:0] fuse_act;
   logic [N_SIG-1:0]  sig_vec;
   logic [COLS-1:0]   col_vec;

   generate
      if (N_PIN < 1 || N_OUT < 1) begin : g_bad_io
         $error("pla_sop_array: need at least one pin and one output");
      end
      if (BASE_TERMS < 1 || TERM_STEP < 0) begin : g_bad_terms
         $error("pla_sop_array: term budget parameters out of range");
      end
      if (SIG_W < 1) begin : g_bad_sig
         $error("pla_sop_array: SIG_W must be at least 1");
      end
   endgenerate

   pla_fuse_store #(.W(FUSE_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_i   (cfg_bit_i),
      .shift_i (cfg_shift_i),
      .load_i  (cfg_load_i),
      .act_o   (fuse_act)
   );

   assign sig_vec = {fb_i, pin_i};

   generate
      for (genvar s = 0; s < N_SIG; s++) begin : g_col
         assign col_vec[2*s]   = sig_vec[s];
         assign col_vec[2*s+1] = ~sig_vec[s];
      end

      for (genvar k = 0; k < N_OUT; k++) begin : g_out
         localparam int NT = pla_pkg::term_count(k, N_OUT, BASE_TERMS, TERM_STEP);
         localparam int ST = pla_pkg::term_start(k, N_OUT, BASE_TERMS, TERM_STEP);
         pla_or_cell #(.N_TERMS(NT), .COLS(COLS)) u_cell (
            .fuse_i (fuse_act[ST*COLS +: NT*COLS]),
            .col_i  (col_vec),
            .sum_o  (sum_o[k])
         );

         // R7: an output whose fuse group is entirely clear stays low.
         a_r7_empty_output: assert property (@(posedge clk) disable iff (!rst_n)
            (fuse_act[ST*COLS +: NT*COLS] == '0) |-> !sum_o[k]);
      end
   endgenerate

   assign sig_o = fuse_act[FUSE_W-1 -: SIG_W];

   // R10: the signature only moves on a load.
   a_r10_sig_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_load_i |=> $stable(sig_o));

   // R1: right after reset everything reads zero.
   a_r1_reset_clear: assert property (@(posedge clk)
      $rose(rst_n) |-> (sum_o == '0) && (sig_o == '0));

endmodule

// File: tb/pla_sop_array_tb.sv
module pla_sop_array_tb;

   localparam int PERIOD = 10;
   localparam int NP     = 12;
   localparam int NO     = 10;
   localparam int NC     = 44;
   localparam int NT     = 120;
   localparam int AW     = NT * NC;
   localparam int FW     = AW + 64;

   logic          clk = 0;
   logic          rst_n = 0;
   logic [NP-1:0] pin = '0;
   logic [NO-1:0] fb = '0;
   logic          sbit = 0, sh = 0, ld = 0;
   logic [NO-1:0] sum;
   logic [63:0]   sig;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   logic [FW-1:0] img;
   logic [FW-1:0] loaded;

   typedef struct {
      string         tag;
      logic [NO-1:0] es;
      logic [63:0]   eg;
   } item_t;
   item_t q[$];

   always #(PERIOD/2) clk = ~clk;

   pla_sop_array u_dut (
      .clk (clk), .rst_n (rst_n), .pin_i (pin), .fb_i (fb),
      .cfg_bit_i (sbit), .cfg_shift_i (sh), .cfg_load_i (ld),
      .sum_o (sum), .sig_o (sig)
   );

   // Reference sums from the requirements R4..R9.
   function automatic logic [NO-1:0] model(input logic [FW-1:0] f,
                                           input logic [NP-1:0] p,
                                           input logic [NO-1:0] b);
      int budget [NO] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};
      logic [NO-1:0] r;
      logic [21:0]   sv;
      int t;
      r  = '0;
      sv = {b, p};
      t  = 0;
      for (int k = 0; k < NO; k++) begin
         for (int j = 0; j < budget[k]; j++) begin
            bit any, v;
            any = 0; v = 1;
            for (int c = 0; c < NC; c++) begin
               if (f[t*NC + c]) begin
                  any = 1;
                  v = v & (c[0] ? ~sv[c/2] : sv[c/2]);
               end
            end
            if (any && v) r[k] = 1'b1;
            t++;
         end
      end
      return r;
   endfunction

   task automatic expect_now(input string tag);
      item_t it;
      it.tag = tag;
      it.es  = model(loaded, pin, fb);
      it.eg  = loaded[FW-1 -: 64];
      q.push_back(it);
      wait (q.size() == 0);
      #1;
   endtask

   // Monitor: pops expected items and compares with the ports.
   initial begin
      forever begin
         item_t it;
         wait (q.size() != 0);
         #1;
         it = q.pop_front();
         total++;
         if (sum !== it.es || sig !== it.eg) begin
            bad++;
            $display("FAIL %s: sum=%h sig=%h expected sum=%h sig=%h",
                     it.tag, sum, sig, it.es, it.eg);
         end
      end
   end

   task automatic shift_image(input logic [FW-1:0] f);
      for (int i = FW - 1; i >= 0; i--) begin
         @(negedge clk);
         sbit = f[i];
         sh   = 1;
      end
      @(negedge clk);
      sh = 0;
   endtask

   task automatic pulse_load(input logic [FW-1:0] f);
      @(negedge clk);
      ld = 1;
      @(negedge clk);
      ld = 0;
      loaded = f;
   endtask

   task automatic set_fuse(input int term, input int col);
      img[term*NC + col] = 1'b1;
   endtask

   task automatic apply(input logic [NP-1:0] p, input logic [NO-1:0] b, input string tag);
      #3;
      pin = p;
      fb  = b;
      expect_now(tag);
   endtask

   task automatic random_image();
      img = '0;
      for (int t = 0; t < NT; t++) begin
         if ($urandom % 6 != 0) begin
            int n;
            n = 1 + $urandom % 2;
            for (int m = 0; m < n; m++) set_fuse(t, $urandom % NC);
         end
      end
      img[FW-1 -: 64] = {$urandom, $urandom};
   endtask

   initial begin
      #(PERIOD * 150000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      loaded = '0;
      img    = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      expect_now("R1 reset clear");
      pin = '1; fb = '1;
      expect_now("R1 reset clear with inputs high");
      rst_n = 1;
      @(negedge clk);

      // Hand-placed image at term budget edges.
      img = '0;
      set_fuse(0, 0);  set_fuse(0, 3);   // out0 t0: pin0 & ~pin1
      set_fuse(43, 22);                  // out3 last term: pin11
      set_fuse(59, 10); set_fuse(59, 11);// out4 last term: pin5 & ~pin5
      set_fuse(60, 25);                  // out5 first term: ~fb0
      set_fuse(119, 42);                 // out9 last term: fb9
      set_fuse(70, 4); set_fuse(70, 6); set_fuse(70, 9); // out5: pin2 & pin3 & ~pin4
      img[FW-1 -: 64] = 64'hA5C3_0F1E_9B7D_2468;
      shift_image(img);
      pulse_load(img);

      // R2 + R10: asymmetric signature reads back intact.
      apply('0, '0, "R2 R10 signature order");
      apply(12'h001, 10'h001, "R4 R5 pin0 true, pin1 ignored-low");
      apply(12'h003, 10'h001, "R4 complement column of pin1");
      apply(12'h800, 10'h000, "R9 last term of out3");
      apply(12'h020, 10'h3FF, "R6 both polarities of pin5");
      apply(12'h000, 10'h200, "R9 last term of out9");
      apply(12'h00C, 10'h001, "R8 second term of out5");
      apply(12'h01C, 10'h001, "R5 R8 pin4 blocks out5 term");
      // R11: inputs change with no clock edge in between
      pin = 12'h001; fb = 10'h000;
      #1 expect_now("R11 comb response A");
      pin = 12'h800;
      #1 expect_now("R11 comb response B");

      // R3: shift a different image without loading.
      begin
         logic [FW-1:0] keep;
         keep = img;
         random_image();
         shift_image(img);
         apply(12'h001, 10'h000, "R3 shift without load holds A");
         apply(12'h800, 10'h200, "R3 shift without load holds B");
         pulse_load(img);
         apply(12'h001, 10'h000, "R3 load takes shadow");
         if (keep == img) $display("note: identical images");
      end
      for (int i = 0; i < 25; i++)
         apply($urandom, $urandom, "R4 R8 random image one");

      random_image();
      shift_image(img);
      pulse_load(img);
      for (int i = 0; i < 25; i++)
         apply($urandom, $urandom, "R4 R8 random image two");

      // R7 + R10: empty AND plane, full signature.
      img = '0;
      img[FW-1 -: 64] = '1;
      shift_image(img);
      pulse_load(img);
      for (int i = 0; i < 6; i++)
         apply($urandom, $urandom, "R7 R10 empty terms stay low");

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule